// File: doc/BRIEF.md
# Display-List Coprocessor Sequencer

This block walks a list of two-word instructions held in memory and acts on them. It fetches words through a request/grant port, always reading both words of an instruction before it acts. It knows three operations. A register write sends an immediate value to an 8-bit register address. A beam hold parks the sequencer until an external beam comparator reports that its condition is true. A conditional hop steps over the next instruction when that condition is true.

Requests go out only in odd memory slots, which the environment marks on `slot_odd`, so the sequencer never competes with the even-slot traffic. While a hold is pending, the sequencer leaves the memory port completely idle. It never stops by itself. A frame-restart pulse reloads the program counter from location register 0, whatever the sequencer is doing. A register write that lands on one of the jump-strobe addresses reloads the program counter from the matching location register.

Top module: `dlist_seq`

## Requirements
- R1: Decode. If bit 0 of the first word is 0, the instruction is a register write. If it is 1 and bit 0 of the second word is 0, it is a beam hold. If both bits 0 are 1, it is a conditional hop.
- R2: `mem_req` is high only in a cycle where `slot_odd` and `dma_en` are high, `rst` and `frame_restart` are low, and the sequencer is fetching. A granted request reads the word at `mem_addr` in that same cycle.
- R3: A register write drives `reg_we` high for one cycle, in the cycle after the grant of its second word. `reg_addr` is bits 8..1 of the first word and `reg_wdata` is the second word. With no grant stalls, the next instruction's first fetch comes 4 cycles after this instruction's first fetch.
- R4: During a beam hold, no requests are issued. The hold ends in an odd slot where `cond_true` is high, and that slot is not used for a fetch. With the condition already true, the next first fetch comes 6 cycles after the hold's first fetch.
- R5: A conditional hop samples `cond_true` in the cycle after its second word's grant. If the condition is true, the program counter advances by 2 more words and the next instruction is skipped. If it is false, execution continues with the next instruction.
- R6: A register write to address `JMP_BASE+k` also appears on the write bus. The next fetch then comes from location register k, which is bits [k*ADDR_W +: ADDR_W] of `loc_addrs`.
- R7: A `frame_restart` cycle issues no request and overrides any pending state, including a hold. The next fetch comes from location register 0.
- R8: While `dma_en` is low, nothing is fetched and `reg_we` stays low.
- R9: The program counter advances by one word per granted fetch and wraps modulo 2^ADDR_W.
- R10: A request that is not granted leaves the state and the address unchanged. It is repeated in the next odd slot.
- R11: While `rst` is high, `mem_req` and `reg_we` are low. After reset, the first fetch is from address 0.
- R12: `cmp_pos` carries bits 15..1 of the first word and `cmp_mask` carries bits 14..1 of the second word of the current instruction. `cmp_active` is high while a hold or a hop evaluation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Enables instruction fetch |
| slot_odd | input | 1 | High in odd memory slots |
| frame_restart | input | 1 | Pulse that restarts the list from location 0 |
| loc_addrs | input | NUM_LOC*ADDR_W | Packed location registers |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_gnt | input | 1 | Grant for the current request |
| mem_rdata | input | 16 | Read word, valid with the grant |
| cmp_pos | output | 15 | Beam position for the comparator |
| cmp_mask | output | 14 | Compare enables for the comparator |
| cmp_active | output | 1 | A comparator decision is pending |
| cond_true | input | 1 | Comparator result |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register word address |
| reg_wdata | output | 16 | Register write data |

## Verification
The bench builds the block with ADDR_W=8, two location registers and JMP_BASE=0x44. The narrow address brings counter wrap within reach of a few hundred cycles, as a list of null register writes runs off the top of memory. The two strobes let a write jump mid-list to location 1, and let a frame restart return to location 0. A grant pattern that withholds one odd slot in seven, together with a bench-side masked comparator whose beam value is moved between phases, makes both hop outcomes, immediate and blocked holds, and retries all occur.

// File: rtl/dlseq_pkg.sv
package dlseq_pkg;
    localparam int WORD_W = 16;
    localparam int REGA_W = 8;
    localparam int POS_W  = 15;
    localparam int MASK_W = 14;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SQ_OP1  = 2'd0,
        SQ_OP2  = 2'd1,
        SQ_TEST = 2'd2,
        SQ_HOLD = 2'd3
    } sq_state_e;

    typedef enum logic [1:0] {
        OP_MOVE = 2'd0,
        OP_WAIT = 2'd1,
        OP_SKIP = 2'd2
    } op_e;

    typedef struct packed {
        logic              we;
        logic [REGA_W-1:0] addr;
        word_t             data;
    } wr_s;

    // R1: operation class from the low bits of both words
    function automatic op_e classify(word_t w1, word_t w2);
        if (!w1[0])      return OP_MOVE;
        else if (!w2[0]) return OP_WAIT;
        else             return OP_SKIP;
    endfunction
endpackage

// File: rtl/dlseq_ctrl.sv
module dlseq_ctrl
    import dlseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              slot_odd,
    input  logic              frame_restart,
    input  logic              mem_gnt,
    input  logic              cond_true,
    input  word_t             mem_rdata,
    output logic              mem_req,
    output logic              fetch_fire,
    output logic              exec_move,
    output logic              skip_take,
    output logic              cmp_active,
    output logic [POS_W-1:0]  cmp_pos,
    output logic [MASK_W-1:0] cmp_mask,
    output logic [REGA_W-1:0] move_dest
);
    sq_state_e         st_q, st_d;
    word_t             ir1_q;
    logic [MASK_W-1:0] ir2_q;
    op_e               op_now;

    always_comb begin
        mem_req    = !rst && dma_en && slot_odd && !frame_restart &&
                     (st_q == SQ_OP1 || st_q == SQ_OP2);
        fetch_fire = mem_req && mem_gnt;
        op_now     = classify(ir1_q, mem_rdata);
        exec_move  = fetch_fire && (st_q == SQ_OP2) && (op_now == OP_MOVE);
        skip_take  = !rst && !frame_restart && (st_q == SQ_TEST) && cond_true;
        cmp_active = (st_q == SQ_TEST) || (st_q == SQ_HOLD);
        cmp_pos    = ir1_q[POS_W:1];
        cmp_mask   = ir2_q;
        move_dest  = ir1_q[REGA_W:1];

        st_d = st_q;
        case (st_q)
            SQ_OP1:  if (fetch_fire) st_d = SQ_OP2;
            SQ_OP2:  if (fetch_fire) begin
                         case (op_now)
                             OP_MOVE: st_d = SQ_OP1;
                             OP_WAIT: st_d = SQ_HOLD;
                             default: st_d = SQ_TEST;
                         endcase
                     end
            SQ_TEST: st_d = SQ_OP1;
            SQ_HOLD: if (slot_odd && cond_true) st_d = SQ_OP1;
            default: st_d = SQ_OP1;
        endcase
        if (frame_restart) st_d = SQ_OP1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_OP1;
            ir1_q <= '0;
            ir2_q <= '0;
        end else begin
            st_q <= st_d;
            if (fetch_fire && st_q == SQ_OP1) ir1_q <= mem_rdata;
            if (fetch_fire && st_q == SQ_OP2) ir2_q <= mem_rdata[MASK_W:1];
        end
    end

    // R4: a hold is left only through an odd slot with a true condition
    a_r4_wake_on_odd: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_OP1 && $past(st_q == SQ_HOLD) && !$past(frame_restart))
            |-> $past(slot_odd && cond_true));

    // R10: an ungranted request leaves the sequencer where it was
    a_r10_retry_holds: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> $stable(st_q));
endmodule

// File: rtl/dlseq_pc.sv
module dlseq_pc #(
    parameter int ADDR_W  = 18,
    parameter int NUM_LOC = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      step,
    input  logic                      skip,
    input  logic [NUM_LOC-1:0]        jump_hit,
    input  logic [NUM_LOC*ADDR_W-1:0] loc_flat,
    output logic [ADDR_W-1:0]         pc
);
    localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO_W = ADDR_W'(2);

    logic [ADDR_W-1:0] loc [NUM_LOC];
    logic [ADDR_W-1:0] jump_tgt;

    generate
        for (genvar k = 0; k < NUM_LOC; k++) begin : g_loc
            assign loc[k] = loc_flat[k*ADDR_W +: ADDR_W];
        end
    endgenerate

    always_comb begin
        jump_tgt = '0;
        for (int k = NUM_LOC - 1; k >= 0; k--) begin
            if (jump_hit[k]) jump_tgt = loc[k];
        end
    end

    // R9: arithmetic wraps naturally at the counter width
    always_ff @(posedge clk) begin
        if (rst)            pc <= '0;
        else if (restart)   pc <= loc[0];
        else if (|jump_hit) pc <= jump_tgt;
        else if (skip)      pc <= pc + TWO_W;
        else if (step)      pc <= pc + ONE_W;
    end

    // R7: frame restart lands on location 0
    a_r7_restart_load: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pc == $past(loc_flat[ADDR_W-1:0])));

    // R9: the counter moves only on a fetch, hop, jump or restart
    a_r9_pc_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !(restart || step || skip || (|jump_hit)) |=> $stable(pc));
endmodule

// File: rtl/dlseq_wbus.sv
module dlseq_wbus
    import dlseq_pkg::*;
#(
    parameter int NUM_LOC  = 2,
    parameter int JMP_BASE = 'h44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  logic [REGA_W-1:0] dest,
    input  word_t             data,
    output logic [NUM_LOC-1:0] jump_hit,
    output wr_s               wr
);
    generate
        for (genvar k = 0; k < NUM_LOC; k++) begin : g_strobe
            localparam logic [REGA_W-1:0] STROBE_A = REGA_W'(JMP_BASE + k);
            assign jump_hit[k] = exec && (dest == STROBE_A);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr <= '0;
        end else begin
            wr.we <= exec;
            if (exec) begin
                wr.addr <= dest;
                wr.data <= data;
            end
        end
    end

    // R6: a strobe hit is also visible as a write in the strobe range
    a_r6_strobe_written: assert property (@(posedge clk) disable iff (rst)
        (|jump_hit) |=> (wr.we && wr.addr >= REGA_W'(JMP_BASE)));
endmodule

// File: rtl/dlist_seq.sv
module dlist_seq
    import dlseq_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int NUM_LOC  = 2,
    parameter int JMP_BASE = 'h44
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      dma_en,
    input  logic                      slot_odd,
    input  logic                      frame_restart,
    input  logic [NUM_LOC*ADDR_W-1:0] loc_addrs,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic                      mem_gnt,
    input  logic [15:0]               mem_rdata,
    output logic [14:0]               cmp_pos,
    output logic [13:0]               cmp_mask,
    output logic                      cmp_active,
    input  logic                      cond_true,
    output logic                      reg_we,
    output logic [7:0]                reg_addr,
    output logic [15:0]               reg_wdata
);
    logic              fetch_fire, exec_move, skip_take;
    logic [REGA_W-1:0] move_dest;
    logic [NUM_LOC-1:0] jump_hit;
    wr_s               wr;

    dlseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .dma_en(dma_en), .slot_odd(slot_odd),
        .frame_restart(frame_restart), .mem_gnt(mem_gnt), .cond_true(cond_true),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .fetch_fire(fetch_fire),
        .exec_move(exec_move), .skip_take(skip_take), .cmp_active(cmp_active),
        .cmp_pos(cmp_pos), .cmp_mask(cmp_mask), .move_dest(move_dest)
    );

    dlseq_pc #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC)) u_pc (
        .clk(clk), .rst(rst), .restart(frame_restart), .step(fetch_fire),
        .skip(skip_take), .jump_hit(jump_hit), .loc_flat(loc_addrs), .pc(mem_addr)
    );

    dlseq_wbus #(.NUM_LOC(NUM_LOC), .JMP_BASE(JMP_BASE)) u_wbus (
        .clk(clk), .rst(rst), .exec(exec_move), .dest(move_dest),
        .data(mem_rdata), .jump_hit(jump_hit), .wr(wr)
    );

    assign reg_we    = wr.we;
    assign reg_addr  = wr.addr;
    assign reg_wdata = wr.data;

    // R8: every write stems from a cycle with fetching enabled
    a_r8_we_needs_dma: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(dma_en));

    // R4: the memory port is idle while a comparator decision is pending
    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        cmp_active |-> !mem_req);
endmodule

// File: tb/tb_dlist_seq.sv
module tb_dlist_seq;
    localparam int PERIOD = 10;
    localparam int AW     = 8;
    localparam int NL     = 2;
    localparam int JB     = 'h44;
    localparam int LOC0   = 'h00;
    localparam int LOC1   = 'h40;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic rst, dma_en, slot_odd, frame_restart, mem_gnt, cond_true;
    logic mem_req, cmp_active, reg_we;
    logic [NL*AW-1:0] loc_addrs;
    logic [AW-1:0]    mem_addr;
    logic [15:0]      mem_rdata, reg_wdata;
    logic [14:0]      cmp_pos, beam;
    logic [13:0]      cmp_mask;
    logic [7:0]       reg_addr;
    logic [15:0]      mem [256];

    function automatic logic beam_ok(logic [14:0] b, logic [14:0] p, logic [13:0] m);
        logic [14:0] mm;
        mm = {1'b1, m};
        return (b & mm) >= (p & mm);
    endfunction

    assign mem_rdata = mem[mem_addr];
    assign cond_true = beam_ok(beam, cmp_pos, cmp_mask);

    dlist_seq #(.ADDR_W(AW), .NUM_LOC(NL), .JMP_BASE(JB)) dut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .slot_odd(slot_odd),
        .frame_restart(frame_restart), .loc_addrs(loc_addrs), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .cmp_pos(cmp_pos), .cmp_mask(cmp_mask), .cmp_active(cmp_active),
        .cond_true(cond_true), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int m_st = 0, m_pc = 0;
    logic [15:0] m_w1 = '0, m_w2 = '0, m_wd = '0;
    logic [7:0]  m_wa = '0;
    bit   m_we = 0;
    bit   p_dma = 0, p_restart = 0;
    logic [14:0] p_beam = '0;
    logic [23:0] wlog[$];
    bit   wrap_seen = 0;
    int   last_fire = -1, req_window = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step_cycle();
        bit req_e, fire_e, cnd;
        @(negedge clk);
        slot_odd      = cyc[0];
        mem_gnt       = (cyc % 7) != 1;
        dma_en        = p_dma;
        frame_restart = p_restart;
        beam          = p_beam;
        #1;
        req_e = dma_en && slot_odd && !frame_restart && (m_st == 0 || m_st == 1);
        chk(mem_req === req_e, "R2 R4 R10", "mem_req", int'(mem_req), int'(req_e));
        if (req_e) chk(mem_addr === AW'(m_pc), "R9", "mem_addr", int'(mem_addr), m_pc);
        chk(reg_we === m_we, "R3 R8", "reg_we", int'(reg_we), int'(m_we));
        if (m_we) begin
            chk(reg_addr === m_wa, "R3 R6", "reg_addr", int'(reg_addr), int'(m_wa));
            chk(reg_wdata === m_wd, "R3", "reg_wdata", int'(reg_wdata), int'(m_wd));
        end
        if (m_st >= 2) begin
            chk(cmp_pos === m_w1[15:1], "R12", "cmp_pos", int'(cmp_pos), int'(m_w1[15:1]));
            chk(cmp_mask === m_w2[14:1], "R12", "cmp_mask", int'(cmp_mask), int'(m_w2[14:1]));
            chk(cmp_active === 1'b1, "R12", "cmp_active", int'(cmp_active), 1);
        end
        if (reg_we) wlog.push_back({reg_addr, reg_wdata});
        if (mem_req) req_window++;
        fire_e = req_e && mem_gnt;
        if (fire_e) begin
            if (last_fire == 255 && m_pc == 0) wrap_seen = 1;
            last_fire = m_pc;
        end
        cnd  = beam_ok(beam, m_w1[15:1], m_w2[14:1]);
        m_we = 0;
        if (frame_restart) begin
            m_pc = LOC0;
            m_st = 0;
        end else begin
            case (m_st)
                0: if (fire_e) begin
                       m_w1 = mem[m_pc];
                       m_pc = (m_pc + 1) % 256;
                       m_st = 1;
                   end
                1: if (fire_e) begin
                       m_w2 = mem[m_pc];
                       m_pc = (m_pc + 1) % 256;
                       if (!m_w1[0]) begin
                           m_we = 1; m_wa = m_w1[8:1]; m_wd = m_w2;
                           if (int'(m_wa) == JB) m_pc = LOC0;
                           else if (int'(m_wa) == JB + 1) m_pc = LOC1;
                           m_st = 0;
                       end else if (!m_w2[0]) m_st = 3;
                       else m_st = 2;
                   end
                2: begin
                       if (cnd) m_pc = (m_pc + 2) % 256;
                       m_st = 0;
                   end
                default: if (slot_odd && cnd) m_st = 0;
            endcase
        end
        cyc++;
    endtask

    task automatic check_list(string tag);
        logic [23:0] exp [4];
        exp[0] = {8'h20, 16'h1111};
        exp[1] = {8'h22, 16'hBEEF};
        exp[2] = {8'h45, 16'h0000};
        exp[3] = {8'h23, 16'h2222};
        chk(wlog.size() == 4, tag, "write count", wlog.size(), 4);
        if (wlog.size() == 4)
            for (int i = 0; i < 4; i++)
                chk(wlog[i] == exp[i], tag, "write entry", int'(wlog[i]), int'(exp[i]));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int beef, found;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        mem[8'h00] = 16'h0040; mem[8'h01] = 16'h1111;  // write 0x20
        mem[8'h02] = 16'h0801; mem[8'h03] = 16'hFFFE;  // hold, pos 0x0400
        mem[8'h04] = 16'h1001; mem[8'h05] = 16'hFF01;  // hop, pos 0x0800
        mem[8'h06] = 16'h0042; mem[8'h07] = 16'hDEAD;  // write 0x21
        mem[8'h08] = 16'hE001; mem[8'h09] = 16'hFFFF;  // hop, pos 0x7000
        mem[8'h0A] = 16'h0044; mem[8'h0B] = 16'hBEEF;  // write 0x22
        mem[8'h0C] = 16'h008A; mem[8'h0D] = 16'h0000;  // strobe 0x45
        mem[8'h40] = 16'h0046; mem[8'h41] = 16'h2222;  // write 0x23
        mem[8'h42] = 16'hFFFF; mem[8'h43] = 16'hFFFE;  // hold, pos 0x7FFF
        mem[8'h44] = 16'h0048; mem[8'h45] = 16'h3333;  // write 0x24
        loc_addrs = {8'(LOC1), 8'(LOC0)};
        rst = 1; dma_en = 1; slot_odd = 1; frame_restart = 0; mem_gnt = 1; beam = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(mem_req === 1'b0, "R11", "mem_req in reset", int'(mem_req), 0);
        chk(reg_we === 1'b0, "R11", "reg_we in reset", int'(reg_we), 0);
        dma_en = 0;
        rst = 0;

        // R1 R3 R5 R6: main list with one hop taken and one not
        p_dma = 1; p_beam = 15'h1000;
        repeat (150) step_cycle();
        check_list("R1 R5 R6");

        // R4: final hold blocks the port
        req_window = 0;
        repeat (40) step_cycle();
        chk(req_window == 0, "R4", "requests during hold", req_window, 0);
        chk(wlog.size() == 4, "R4", "writes during hold", wlog.size(), 4);

        // R7: restart out of a pending hold
        wlog.delete();
        p_restart = 1; step_cycle(); p_restart = 0;
        repeat (150) step_cycle();
        check_list("R7");

        // R8: fetching disabled
        wlog.delete();
        p_dma = 0; p_restart = 1; step_cycle(); p_restart = 0;
        req_window = 0;
        repeat (40) step_cycle();
        chk(req_window == 0, "R8", "requests with dma off", req_window, 0);
        chk(wlog.size() == 0, "R8", "writes with dma off", wlog.size(), 0);
        p_dma = 1;
        repeat (150) step_cycle();
        check_list("R8");

        // R9 R4 R5: hold releases, list runs off the top and wraps
        wlog.delete();
        p_beam = 15'h7FFF;
        repeat (1200) step_cycle();
        chk(wrap_seen, "R9", "address wrap seen", int'(wrap_seen), 1);
        found = 0; beef = 0;
        foreach (wlog[i]) begin
            if (wlog[i] == {8'h24, 16'h3333}) found++;
            if (wlog[i] == {8'h22, 16'hBEEF}) beef++;
        end
        chk(found >= 1, "R4", "write after released hold", found, 1);
        chk(beef == 0, "R5", "skipped write count", beef, 0);

        summary();
        $finish;
    end
endmodule